// File: doc/BRIEF.md
# Interrupt-Capable GPIO Channel

This block is one memory-mapped general-purpose I/O channel of up to sixteen pins. Software picks each pin's direction, drives output pins from an output latch, and reads the current level of every pin. Input levels pass through a two-stage synchronizer before anything else sees them.

Each pin has its own interrupt detector with five trigger kinds: rising edge, falling edge, both edges, level high and level low. When a pin's enable bit is set and its trigger condition holds, a sticky status bit is latched. Software clears status bits by writing ones to a clear register. A mask, set and cleared through two separate write-one registers, hides status from the single combined interrupt request. The register port is a plain 32-bit word-addressed bus with a write strobe and a combinational read path.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: Direction register (word 8) bit 1 drives `pin_oe` for that pin, and `pin_out` follows the output register (word 6). Bits at and above `PINS` in the direction, output, enable and mask registers read back as zero.
- R3: The input register (word 7) returns each pin's level after a two-flop synchronizer. A change on `pin_in` appears on the second clock edge after it is applied.
- R4: Pin p < 8 takes its 3-bit trigger code from word 9 bits [4p+2:4p]. Pin p >= 8 takes it from word 10 bits [4(p-8)+2:4(p-8)]. The codes are 0 falling, 1 rising, 2 level low, 3 level high and 4 both edges. The top bit of each nibble and the nibbles of absent pins read zero. Codes 5 to 7 never trigger.
- R5: An edge trigger latches the pin's sticky status bit (word 1) on the third clock edge after the pin changes. An edge of the opposite kind has no effect.
- R6: In a level mode the status bit is set on every cycle the level holds. A clear written while the level still holds leaves the bit set.
- R7: A status bit can be set only while that pin's enable bit (word 0) is 1.
- R8: Writing a 1 to a bit of word 3 clears that status bit. Zero bits leave status unchanged.
- R9: Writing ones to word 4 sets mask bits and writing ones to word 5 clears them. Both words read back the mask. The display register (word 2) reads status AND NOT mask.
- R10: `irq` is high exactly when any display bit is 1.
- R11: Writes to words 1, 2 and 7 are ignored. Word 3 and words 11 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wr_data` |
| addr | input | 4 | Word offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | PINS | Pin levels from the pads |
| pin_out | output | PINS | Output latch contents |
| pin_oe | output | PINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench counts the exact edge on which synchronized input and status appear. A design with one synchronizer stage too few or too many reports at the wrong cycle. It writes a clear while a level condition still holds: a design that lets the clear win would drop a live level interrupt. It drives edges of the wrong polarity and the reserved codes 5 to 7, which a loose decoder would turn into spurious status. It also checks masking against the display register and `irq`, and checks that writes of zero to the clear register leave status alone.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_IEN   = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_DISP  = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_MSET  = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_MCLR  = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_OUT   = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_IN    = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_MODE0 = 4'd9;
    localparam logic [ADDR_W-1:0] OFF_MODE1 = 4'd10;

    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpx_pin_det.sv
module gpx_pin_det
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [2:0] mode,
    output logic       evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        unique case (mode)
            TRIG_FALL: evt = prev_q & ~lvl;
            TRIG_RISE: evt = ~prev_q & lvl;
            TRIG_LOW:  evt = ~lvl;
            TRIG_HIGH: evt = lvl;
            TRIG_BOTH: evt = prev_q ^ lvl;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpx_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int PAD  = 32 - PINS;
    localparam int NIBS = 8;

    logic [PINS-1:0] ien_q, stat_q, mask_q, out_q, dir_q;
    logic [PINS-1:0] lvl, evt, disp;
    logic [2:0]      mode_q [PINS];
    logic [31:0]     mode0_rd, mode1_rd;

    wire wr_ien  = wr_en && addr == OFF_IEN;
    wire wr_clr  = wr_en && addr == OFF_CLR;
    wire wr_mset = wr_en && addr == OFF_MSET;
    wire wr_mclr = wr_en && addr == OFF_MCLR;
    wire wr_out  = wr_en && addr == OFF_OUT;
    wire wr_dir  = wr_en && addr == OFF_DIR;

    gpx_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int NIB = (p % NIBS) * 4;
        localparam logic [3:0] MOFF = (p < NIBS) ? OFF_MODE0 : OFF_MODE1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mode_q[p] <= 3'd0;
            else if (wr_en && addr == MOFF)  mode_q[p] <= wr_data[NIB +: 3];
        end

        gpx_pin_det u_det (
            .clk(clk), .rst_n(rst_n), .lvl(lvl[p]),
            .mode(mode_q[p]), .evt(evt[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            stat_q <= '0;
            mask_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_ien) ien_q <= wr_data[PINS-1:0];
            if (wr_out) out_q <= wr_data[PINS-1:0];
            if (wr_dir) dir_q <= wr_data[PINS-1:0];
            if (wr_mset)      mask_q <= mask_q | wr_data[PINS-1:0];
            else if (wr_mclr) mask_q <= mask_q & ~wr_data[PINS-1:0];
            // a live trigger outranks a clear in the same cycle
            stat_q <= (stat_q & ~({PINS{wr_clr}} & wr_data[PINS-1:0]))
                    | (ien_q & evt);
        end
    end

    always_comb begin
        mode0_rd = '0;
        mode1_rd = '0;
        for (int p = 0; p < PINS; p++) begin
            if (p < NIBS) mode0_rd[(p % NIBS)*4 +: 3] = mode_q[p];
            else          mode1_rd[(p % NIBS)*4 +: 3] = mode_q[p];
        end
    end

    assign disp    = stat_q & ~mask_q;
    assign irq     = |disp;
    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    always_comb begin
        unique case (addr)
            OFF_IEN:              rd_data = {{PAD{1'b0}}, ien_q};
            OFF_STAT:             rd_data = {{PAD{1'b0}}, stat_q};
            OFF_DISP:             rd_data = {{PAD{1'b0}}, disp};
            OFF_MSET, OFF_MCLR:   rd_data = {{PAD{1'b0}}, mask_q};
            OFF_OUT:              rd_data = {{PAD{1'b0}}, out_q};
            OFF_IN:               rd_data = {{PAD{1'b0}}, lvl};
            OFF_DIR:              rd_data = {{PAD{1'b0}}, dir_q};
            OFF_MODE0:            rd_data = mode0_rd;
            OFF_MODE1:            rd_data = mode1_rd;
            default:              rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk
    import gpx_pkg::*;
#(
    parameter int PINS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [3:0]      addr,
    input logic [31:0]     wr_data,
    input logic [31:0]     rd_data,
    input logic [PINS-1:0] pin_oe,
    input logic            irq,
    input logic [PINS-1:0] stat,
    input logic [PINS-1:0] ien
);
    // R8
    no_lost_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr != OFF_CLR) |=> ((stat & $past(stat)) == $past(stat)));

    // R7
    no_disabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~$past(stat) & ~$past(ien)) == '0);

    // R2
    dir_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DIR) |=> pin_oe == $past(wr_data[PINS-1:0]));

    // R9
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_MSET && wr_data[PINS-1:0] == '1) |=> !irq);

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat != '0);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > OFF_MODE1 || addr == OFF_CLR) |-> rd_data == '0);
endmodule

bind gpio_irq_port gpx_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_oe(pin_oe), .irq(irq),
    .stat(stat_q), .ien(ien_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      addr = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port #(.PINS(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: kind 0 read data, 1 irq, 2 pin_oe, 3 pin_out
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {31'd0, irq};
                    2:       act = {{(32-PINS){1'b0}}, pin_oe};
                    default: act = {{(32-PINS){1'b0}}, pin_out};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [3:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        wr_en = 1'b0;
        addr  = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input logic [PINS-1:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int a = 0; a < 16; a++) rd(a[3:0], 32'h0, "R1 reset read");
        expect_item(1, 4'd0, 32'h0, "R1 irq at reset");
        expect_item(2, 4'd0, 32'h0, "R1 oe at reset");
        expect_item(3, 4'd0, 32'h0, "R1 out at reset");

        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, 32'h0000_0FFF, "R2 direction upper bits");
        expect_item(2, 4'd0, 32'hFFF, "R2 oe all");
        wr(4'd6, 32'hA5A5_A5A5);
        rd(4'd6, 32'h0000_05A5, "R2 output readback");
        expect_item(3, 4'd0, 32'h5A5, "R2 pin_out");
        wr(4'd8, 32'h0000_000F);
        expect_item(2, 4'd0, 32'h00F, "R2 oe partial");

        wr(4'd1, 32'hFFF); rd(4'd1, 32'h0, "R11 status ignores write");
        wr(4'd2, 32'hFFF); rd(4'd2, 32'h0, "R11 display ignores write");
        wr(4'd7, 32'hFFF); rd(4'd7, 32'h0, "R11 input ignores write");
        wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, 32'h0, "R11 reserved reads zero");
        rd(4'd3, 32'h0, "R11 clear reads zero");

        set_pin(12'h3C3);
        rd(4'd7, 32'h0, "R3 not yet after one edge");
        rd(4'd7, 32'h3C3, "R3 visible after two edges");
        set_pin(12'h000); idle(3);

        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, 32'h7777_7777, "R4 mode0 nibble top bit");
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, 32'h0000_7777, "R4 mode1 absent pins");
        wr(4'd10, 32'h0);
        wr(4'd9, 32'h0054_2301);

        set_pin(12'h001); idle(3);
        rd(4'd1, 32'h0, "R7 disabled pin no status");
        set_pin(12'h000); idle(3);
        wr(4'd0, 32'h0000_0033);
        rd(4'd0, 32'h33, "R7 enable readback");

        set_pin(12'h001); idle(1);
        rd(4'd1, 32'h0, "R5 not set on second edge");
        rd(4'd1, 32'h001, "R5 rising set on third edge");
        expect_item(1, 4'd0, 32'h1, "R10 irq high");
        wr(4'd3, 32'h0);
        rd(4'd1, 32'h001, "R8 zero clear no effect");
        wr(4'd3, 32'h001);
        rd(4'd1, 32'h0, "R8 clear");
        expect_item(1, 4'd0, 32'h0, "R10 irq low");

        set_pin(12'h003); idle(3);
        rd(4'd1, 32'h0, "R5 falling mode ignores rise");
        set_pin(12'h001); idle(3);
        rd(4'd1, 32'h002, "R5 falling edge");
        wr(4'd3, 32'hFFF);
        set_pin(12'h000); idle(3);
        rd(4'd1, 32'h0, "R5 rising mode ignores fall");

        set_pin(12'h010); idle(3);
        rd(4'd1, 32'h010, "R4 both rise");
        wr(4'd3, 32'h010);
        set_pin(12'h000); idle(3);
        rd(4'd1, 32'h010, "R4 both fall");
        wr(4'd3, 32'h010);

        set_pin(12'h020); idle(3);
        rd(4'd1, 32'h0, "R4 code 5 rise no trigger");
        set_pin(12'h000); idle(3);
        rd(4'd1, 32'h0, "R4 code 5 fall no trigger");

        wr(4'd0, 32'h37);
        set_pin(12'h004); idle(3);
        rd(4'd1, 32'h004, "R6 level high set");
        wr(4'd3, 32'h004);
        rd(4'd1, 32'h004, "R6 clear loses to held level");
        set_pin(12'h000); idle(3);
        wr(4'd3, 32'h004);
        rd(4'd1, 32'h0, "R6 clear after release");

        wr(4'd0, 32'h3F);
        rd(4'd1, 32'h008, "R6 level low set");
        set_pin(12'h008); idle(3);
        wr(4'd3, 32'h008);
        rd(4'd1, 32'h0, "R6 level low released");

        set_pin(12'h009); idle(3);
        rd(4'd1, 32'h001, "R9 status before mask");
        wr(4'd4, 32'h001);
        rd(4'd2, 32'h0, "R9 display masked");
        expect_item(1, 4'd0, 32'h0, "R10 masked irq low");
        rd(4'd4, 32'h001, "R9 mask at set word");
        rd(4'd5, 32'h001, "R9 mask at clear word");
        rd(4'd1, 32'h001, "R9 status kept under mask");
        wr(4'd5, 32'h001);
        rd(4'd2, 32'h001, "R9 display unmasked");
        expect_item(1, 4'd0, 32'h1, "R10 unmasked irq high");
        wr(4'd3, 32'h001);
        expect_item(1, 4'd0, 32'h0, "R10 irq after clear");
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, 32'hFFF, "R9 mask upper bits");
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, 32'h0, "R9 mask all cleared");

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule